// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Controller

This block decides whether a maskable interrupt request is taken at the end of the current instruction. The instruction sequencer gives it two phase flags. One marks the next-to-last clock of every instruction, which is the only clock in which the request is looked at. The other marks the final clock, where the instruction completes. A software enable flag, set and cleared by commands from the instruction decoder, gates the sample.

When a request is taken, the controller pulses an accepted strobe and holds back the program counter increment. Once the instruction has completed, it drives an acknowledge machine cycle. During that cycle an external device places a restart or call opcode on the bus in place of the normal fetch. Acceptance clears the software enable, and so does reset. An enable command is armed rather than applied at once: it becomes active only when the instruction after the enabling instruction completes. This lets a return instruction run before another interrupt can be taken.

Top module: `irq_accept_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it is released, `accepted_o`, `ack_o` and `pc_hold_o` are 0. The interrupt enable is cleared, so no request is taken until an enable command has been given and has taken effect (R7).
- R2: The request is sampled only at a rising edge where `samp_slot_i`=1, which marks the next-to-last clock of an instruction. A request is taken only if `irq_i`=1 at that edge and the enable is set. `accepted_o` is then 1 for exactly the one clock after that edge.
- R3: A request that is 0 at the sampling edge is not taken in that instruction, even if `irq_i` is 1 in the final clock (`instr_end_i`=1).
- R4: After a request is taken, `pc_hold_o` is 1 without a break from the clock after the sampling edge up to and including the last clock of the acknowledge cycle. Otherwise it is 0.
- R5: `ack_o` is 1 for exactly ACK_CLKS consecutive clocks per taken request. It starts in the clock after the edge where `instr_end_i`=1 ends the accepting instruction.
- R6: Taking a request clears the enable. Further requests are ignored until a new enable command has taken effect.
- R7: An enable command (`en_cmd_i`=1 in a clock of an instruction that is not its final clock) sets the enable only at the `instr_end_i` edge of the following instruction. Requests sampled before that point are ignored.
- R8: A disable command (`dis_cmd_i`=1) clears the enable from the next clock on, and it cancels an enable command that has not yet taken effect. When both commands are given in the same clock, the disable wins.
- R9: With the enable clear, `irq_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Maskable interrupt request |
| samp_slot_i | input | 1 | High in the next-to-last clock of an instruction |
| instr_end_i | input | 1 | High in the final clock of an instruction |
| en_cmd_i | input | 1 | Enable command from decoder |
| dis_cmd_i | input | 1 | Disable command from decoder |
| accepted_o | output | 1 | One-clock pulse when a request is taken |
| ack_o | output | 1 | Interrupt acknowledge machine cycle |
| pc_hold_o | output | 1 | Inhibit program counter increment |

## Verification
The bench builds the block with ACK_CLKS=3. This is long enough to show that a request held high all through the acknowledge cycle does not start a second one, and that the cycle ends after exactly three clocks. For instruction lengths of two to five clocks, it applies every pattern of the request line across all the clocks of an instruction. The expected acceptance comes from the bit that falls on the sampling clock alone. The bench also walks the enable through its delayed activation, cancellation by disable, clearing by reset and clearing by acceptance.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    // Progress of an enable command that has not yet taken effect
    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_OWN  = 2'd1,   // waiting for the enabling instruction to finish
        ARM_NEXT = 2'd2    // waiting for the following instruction to finish
    } arm_e;

    typedef struct packed {
        logic ie;
        arm_e arm;
    } en_state_t;

    typedef struct packed {
        logic pend;
        logic acc;
    } samp_state_t;

endpackage

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd_i,
    input  logic dis_cmd_i,
    input  logic instr_end_i,
    input  logic take_i,
    output logic ie_o
);

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dis_cmd_i) begin
            st_d.ie  = 1'b0;
            st_d.arm = ARM_IDLE;
        end else if (take_i) begin
            st_d.ie  = 1'b0;
            st_d.arm = ARM_IDLE;
        end else if (en_cmd_i && !st_q.ie) begin
            st_d.arm = instr_end_i ? ARM_NEXT : ARM_OWN;
        end else begin
            unique case (st_q.arm)
                ARM_OWN:  if (instr_end_i) st_d.arm = ARM_NEXT;
                ARM_NEXT: if (instr_end_i) begin
                    st_d.arm = ARM_IDLE;
                    st_d.ie  = 1'b1;
                end
                default:  st_d.arm = ARM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ie: 1'b0, arm: ARM_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign ie_o = st_q.ie;

    // R6
    take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !ie_o);

    // R7
    ie_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie_o) |-> $past(instr_end_i));

    // R8
    dis_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd_i |=> !ie_o);

endmodule

// File: rtl/irq_sampler.sv
module irq_sampler
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic samp_slot_i,
    input  logic instr_end_i,
    input  logic ie_i,
    input  logic ack_busy_i,
    output logic take_o,
    output logic start_o,
    output logic pend_o,
    output logic accepted_o
);

    samp_state_t st_d, st_q;

    // Sample only in the next-to-last clock, never while a previous one is in flight
    assign take_o  = samp_slot_i && irq_i && ie_i && !st_q.pend && !ack_busy_i;
    assign start_o = st_q.pend && instr_end_i;

    always_comb begin
        st_d     = st_q;
        st_d.acc = take_o;
        if (take_o) begin
            st_d.pend = 1'b1;
        end else if (start_o) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o     = st_q.pend;
    assign accepted_o = st_q.acc;

    // R2
    sample_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(accepted_o) |-> $past(samp_slot_i && irq_i));

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accepted_o |=> !accepted_o);

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
    parameter int ACK_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pend_i,
    output logic busy_o,
    output logic ack_o,
    output logic pc_hold_o
);

    localparam int CNT_W = $clog2(ACK_CLKS + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(ACK_CLKS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o    = (cnt_q != '0);
    assign ack_o     = busy_o;
    assign pc_hold_o = pend_i || busy_o;

    // R5
    ack_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> ack_o && pc_hold_o);

    // R5
    no_ack_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !start_i);

    // R4
    hold_during_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_i |-> pc_hold_o);

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl #(
    parameter int ACK_CLKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic samp_slot_i,
    input  logic instr_end_i,
    input  logic en_cmd_i,
    input  logic dis_cmd_i,
    output logic accepted_o,
    output logic ack_o,
    output logic pc_hold_o
);

    logic ie, take, start, pend, busy;

    irq_enable_ctl u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_cmd_i    (en_cmd_i),
        .dis_cmd_i   (dis_cmd_i),
        .instr_end_i (instr_end_i),
        .take_i      (take),
        .ie_o        (ie)
    );

    irq_sampler u_samp (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .samp_slot_i (samp_slot_i),
        .instr_end_i (instr_end_i),
        .ie_i        (ie),
        .ack_busy_i  (busy),
        .take_o      (take),
        .start_o     (start),
        .pend_o      (pend),
        .accepted_o  (accepted_o)
    );

    irq_ack_seq #(.ACK_CLKS(ACK_CLKS)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .pend_i    (pend),
        .busy_o    (busy),
        .ack_o     (ack_o),
        .pc_hold_o (pc_hold_o)
    );

    // R9
    no_take_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !accepted_o);

endmodule

// File: tb/irq_accept_ctrl_tb.sv
module irq_accept_ctrl_tb;

    localparam int ACK = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq = 1'b0, samp_slot = 1'b0, instr_end = 1'b0, en_cmd = 1'b0, dis_cmd = 1'b0;
    logic accepted, ack, pc_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_accept_ctrl #(.ACK_CLKS(ACK)) u_dut (
        .clk (clk), .rst_n (rst_n), .irq_i (irq), .samp_slot_i (samp_slot),
        .instr_end_i (instr_end), .en_cmd_i (en_cmd), .dis_cmd_i (dis_cmd),
        .accepted_o (accepted), .ack_o (ack), .pc_hold_o (pc_hold)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        samp_slot = 1'b0; instr_end = 1'b0; en_cmd = 1'b0; dis_cmd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; idle_inputs(); irq = 1'b0;
        repeat (2) @(negedge clk);
        chk(accepted, 1'b0, "R1 accepted in reset");
        chk(ack, 1'b0, "R1 ack in reset");
        chk(pc_hold, 1'b0, "R1 pc_hold in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(accepted | ack | pc_hold, 1'b0, "R1 outputs after reset");
    endtask

    // One instruction of n clocks; irq driven per clock from pat
    task automatic do_instr(input int n, input logic [7:0] pat, input bit ei,
                            input bit di, input bit exp_acc, input string tag);
        for (int k = 0; k < n; k++) begin
            samp_slot = (k == n - 2);
            instr_end = (k == n - 1);
            irq       = pat[k];
            en_cmd    = ei && (k == 0);
            dis_cmd   = di && (k == 0);
            @(posedge clk);
            @(negedge clk);
            chk(accepted, exp_acc && (k == n - 2), {tag, " R2 accepted"});
            chk(pc_hold, exp_acc && (k >= n - 2), {tag, " R4 pc_hold"});
            chk(ack, exp_acc && (k == n - 1), {tag, " R5 ack start"});
        end
        idle_inputs();
        if (exp_acc) begin
            for (int j = 0; j < ACK; j++) begin
                irq = 1'b1;
                @(posedge clk);
                @(negedge clk);
                chk(ack, j < ACK - 1, {tag, " R5 ack length"});
                chk(pc_hold, j < ACK - 1, {tag, " R4 pc_hold through ack"});
                chk(accepted, 1'b0, {tag, " R6 no re-accept in ack"});
            end
        end
        irq = 1'b0;
    endtask

    task automatic enable_now();
        do_instr(3, 8'hFF, 1'b1, 1'b0, 1'b0, "R7 enabling instr");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R7 instr after enable");
    endtask

    initial begin
        do_reset();
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R1 R9 disabled after reset");

        // Exhaustive request patterns over instruction lengths 2..5
        for (int n = 2; n <= 5; n++) begin
            for (int p = 0; p < (1 << n); p++) begin
                logic [7:0] pat;
                bit hit;
                pat = 8'(p);
                hit = pat[n-2];
                do_reset();
                enable_now();
                do_instr(n, pat, 1'b0, 1'b0, hit,
                         (!hit && pat[n-1]) ? "R3 late request" : "R2 sweep");
                if (hit)
                    do_instr(n, 8'hFF, 1'b0, 1'b0, 1'b0, "R6 cleared after accept");
                else
                    do_instr(n, 8'hFF, 1'b0, 1'b0, 1'b1, "R3 still enabled");
            end
        end

        // Disable command wins and takes effect next clock
        do_reset();
        enable_now();
        do_instr(3, 8'hFF, 1'b0, 1'b1, 1'b0, "R8 disable");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 stays disabled");

        // Disable cancels an armed enable
        do_reset();
        do_instr(3, 8'h00, 1'b1, 1'b0, 1'b0, "R8 arm");
        do_instr(3, 8'hFF, 1'b0, 1'b1, 1'b0, "R8 cancel arm");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 arm cancelled");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 arm cancelled 2");

        // Both commands at once: disable wins
        do_reset();
        do_instr(3, 8'h00, 1'b1, 1'b1, 1'b0, "R8 both cmds");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 both cmds next");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R8 both cmds later");

        // Reset clears an armed enable
        do_reset();
        do_instr(3, 8'h00, 1'b1, 1'b0, 1'b0, "R1 arm before reset");
        do_reset();
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R1 after reset 1");
        do_instr(3, 8'hFF, 1'b0, 1'b0, 1'b0, "R1 after reset 2");

        // Re-enable after acceptance works again, delay observed
        do_reset();
        enable_now();
        do_instr(4, 8'hFF, 1'b0, 1'b0, 1'b1, "R6 first accept");
        do_instr(4, 8'hFF, 1'b1, 1'b0, 1'b0, "R7 re-enable instr");
        do_instr(4, 8'hFF, 1'b0, 1'b0, 1'b0, "R7 return instr");
        do_instr(4, 8'hFF, 1'b0, 1'b0, 1'b1, "R7 accepted after delay");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule